// File: doc/BRIEF.md
# Stereo Zero-Data Detector

This block watches a stereo sample stream one frame at a time and raises a single flag when the stream has gone silent for a long time. There are two ways to be silent. Both channel words can be exactly zero for a long unbroken run. Or the mute request can be held long enough that the muted output is certainly settled. Downstream logic uses the registered flag to engage an external mute, for example to remove residual noise once nothing is being played.

Each frame is marked by a one-cycle strobe, and sample words are only looked at on that strobe. A zero-run counter measures consecutive all-zero frames. A mute-hold counter measures frames during which the mute request stays high. Both counters saturate at their limits. The flag is computed from the next value of both counters, so it responds at the same clock edge that takes in the deciding frame. When mute is released, the flag responds at the next clock edge, with no strobe needed.

Top module: `zdet_top`

## Requirements
- R1: Reset forces the flag low and empties both counters, so a zero run interrupted by reset must start again from the beginning.
- R2: The flag goes high at the clock edge that takes in the 8192nd consecutive frame in which both channels are zero. After 8191 such frames it is still low.
- R3: A frame counts as zero only when all 18 bits of both channel words are 0. A nonzero bit in either channel, whether the lowest bit (value 1) or only the sign bit (18'h20000), breaks the run and restarts the count.
- R4: A frame strobe carrying a nonzero word clears the flag at that same clock edge, unless the mute path qualifies (R6).
- R5: The zero-run counter saturates. The flag stays high however long the zero run lasts, including past 16384 frames.
- R6: With the mute request held and the fully-muted status high, the flag goes high at the edge that takes in the 9214th strobe (8192 + 1022) counted while the request is held. It stays high whatever the sample data is.
- R7: The mute path asserts the flag only while the fully-muted status is high. If the status rises after the hold count has saturated, the flag rises at the next clock edge.
- R8: Dropping the mute request clears the mute-hold count and takes the flag low at the next clock edge, with no strobe needed. Holding the request again needs another full 9214 strobes.
- R9: Sample words that change between strobes have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe, one per frame; samples are valid with it |
| left_smp | input | 18 | Left channel sample, two's complement |
| right_smp | input | 18 | Right channel sample, two's complement |
| mute_req | input | 1 | Mute request level |
| mute_done | input | 1 | Status from the mute ramp: output fully attenuated |
| zero_flag | output | 1 | Registered zero-detect flag |

## Verification
The zero path is driven with long all-zero runs that are broken first by a single low bit in the left word and then by only the sign bit in the right word. This shows whether the zero test covers every bit of both channels, and whether the threshold falls exactly between frame 8191 and frame 8192. The run then continues past 16384 frames, which separates a saturating counter from one that wraps. The mute path is driven with nonzero data while the mute request is held, once with the fully-muted status high and once with it low. This separates the mute path from the zero path and shows whether the status is used as a gate. A release followed by a second full hold checks that the hold count restarts. Samples that change between strobes, and a reset in the middle of a run, show that data is only taken on the strobe and that reset really empties the counters.

// File: rtl/zdet_pkg.sv
package zdet_pkg;
    localparam int unsigned ZDET_SAMPLE_W    = 18;
    localparam int unsigned ZDET_ZERO_FRAMES = 8192;
    localparam int unsigned ZDET_MUTE_FRAMES = 8192 + 1022;
    localparam int unsigned ZDET_CHANNELS    = 2;
endpackage

// File: rtl/zdet_run_counter.sv
module zdet_run_counter #(
    parameter int unsigned LIMIT         = 8192,
    parameter bit          CLEAR_ANYTIME = 1'b0,
    localparam int unsigned CW           = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          keep,
    output logic [CW-1:0] cnt_q,
    output logic          full_nx
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_state_t;

    run_state_t s_d, s_q;
    logic       clr;

    generate
        if (CLEAR_ANYTIME) begin : g_clr_any
            assign clr = !keep;
        end else begin : g_clr_tick
            assign clr = tick && !keep;
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt = '0;
        end else if (tick && (s_q.cnt != LIM)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        full_nx = (s_d.cnt == LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q = s_q.cnt;

    // R5
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && keep && cnt_q == LIM) |=> (cnt_q == LIM));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && keep && cnt_q != LIM) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !keep) |=> (cnt_q == '0));
endmodule

// File: rtl/zdet_top.sv
module zdet_top
    import zdet_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = ZDET_SAMPLE_W,
    parameter int unsigned ZERO_FRAMES = ZDET_ZERO_FRAMES,
    parameter int unsigned MUTE_FRAMES = ZDET_MUTE_FRAMES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_tick,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    input  logic                mute_req,
    input  logic                mute_done,
    output logic                zero_flag
);
    localparam int unsigned ZW = $clog2(ZERO_FRAMES + 1);
    localparam int unsigned MW = $clog2(MUTE_FRAMES + 1);
    localparam int unsigned NCH = ZDET_CHANNELS;

    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t f_d, f_q;

    logic [SAMPLE_W-1:0] smp [NCH];
    logic [NCH-1:0]      ch_zero;
    logic                data_zero;
    logic [ZW-1:0]       z_cnt_q;
    logic [MW-1:0]       m_cnt_q;
    logic                z_full_nx;
    logic                m_full_nx;

    assign smp[0] = left_smp;
    assign smp[1] = right_smp;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            assign ch_zero[g] = (smp[g] == '0);
        end
    endgenerate

    assign data_zero = &ch_zero;

    zdet_run_counter #(
        .LIMIT         (ZERO_FRAMES),
        .CLEAR_ANYTIME (1'b0)
    ) u_zero_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (frame_tick),
        .keep    (data_zero),
        .cnt_q   (z_cnt_q),
        .full_nx (z_full_nx)
    );

    zdet_run_counter #(
        .LIMIT         (MUTE_FRAMES),
        .CLEAR_ANYTIME (1'b1)
    ) u_mute_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (frame_tick),
        .keep    (mute_req),
        .cnt_q   (m_cnt_q),
        .full_nx (m_full_nx)
    );

    always_comb begin
        f_d      = f_q;
        f_d.flag = z_full_nx || (m_full_nx && mute_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign zero_flag = f_q.flag;

    // R4
    nonzero_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !data_zero && !mute_req) |=> !zero_flag);

    // R7
    mute_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !data_zero && !mute_done) |=> !zero_flag);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mute_req) && !frame_tick && (z_cnt_q != ZW'(ZERO_FRAMES))) |=> !zero_flag);

    // R2 and R6
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_flag) |-> ((z_cnt_q == ZW'(ZERO_FRAMES)) ||
                              ((m_cnt_q == MW'(MUTE_FRAMES)) && $past(mute_done))));

    // R9
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_tick && $stable(mute_req) && $stable(mute_done)) |=> $stable(zero_flag));
endmodule

// File: tb/zdet_top_bench.sv
`timescale 1ns/1ps
module zdet_top_bench;
    localparam int ZL = 8192;
    localparam int ML = 9214;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic [17:0] left_smp = '0;
    logic [17:0] right_smp = '0;
    logic        mute_req = 1'b0;
    logic        mute_done = 1'b0;
    logic        zero_flag;

    int checks = 0;
    int fails = 0;
    int zrun = 0;
    int mrun = 0;
    logic tick_seen = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    zdet_top u_zdet_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .left_smp   (left_smp),
        .right_smp  (right_smp),
        .mute_req   (mute_req),
        .mute_done  (mute_done),
        .zero_flag  (zero_flag)
    );

    function automatic bit model_flag();
        return (zrun == ZL) || (mute_req && (mrun == ML) && mute_done);
    endfunction

    task automatic frame(input logic [17:0] l, input logic [17:0] r, input string tag);
        item_t it;
        left_smp   = l;
        right_smp  = r;
        frame_tick = 1'b1;
        if (l == 0 && r == 0) zrun = (zrun < ZL) ? zrun + 1 : zrun;
        else zrun = 0;
        if (mute_req) mrun = (mrun < ML) ? mrun + 1 : mrun;
        else mrun = 0;
        it.exp = model_flag();
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        frame_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_now(input bit exp, input string tag);
        checks++;
        if (zero_flag !== exp) begin
            fails++;
            $display("FAIL %s: zero_flag=%b expected %b", tag, zero_flag, exp);
        end
    endtask

    always @(posedge clk) tick_seen <= frame_tick;

    always @(negedge clk) begin
        if (tick_seen && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (zero_flag !== it.exp) begin
                fails++;
                $display("FAIL %s: zero_flag=%b expected %b (zrun=%0d mrun=%0d)",
                         it.tag, zero_flag, it.exp, zrun, mrun);
            end
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not end, actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check_now(1'b0, "R1 flag during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_now(1'b0, "R1 flag after reset");

        // R3: single low bit and sign bit alone both break the run
        for (int i = 0; i < 100; i++) frame(18'd0, 18'd0, "R2 zero run");
        frame(18'd1, 18'd0, "R3 left lsb");
        for (int i = 0; i < 50; i++) frame(18'd0, 18'd0, "R2 zero run");
        frame(18'd0, 18'h20000, "R3 right sign bit");
        // R2: low through 8191, high at 8192 (checked per frame)
        for (int i = 0; i < ZL - 1; i++) frame(18'd0, 18'd0, "R2 before threshold");
        check_now(1'b0, "R2 after 8191 frames");
        frame(18'd0, 18'd0, "R2 at threshold");

        // R9: samples change without a strobe
        left_smp  = 18'd5;
        right_smp = 18'h3ffff;
        repeat (4) @(negedge clk);
        check_now(1'b1, "R9 data between strobes");

        // R5: keep going past 16384
        for (int i = 0; i < 8208; i++) frame(18'd0, 18'd0, "R5 saturated run");
        check_now(1'b1, "R5 long run");

        // R4
        frame(18'd3, 18'd3, "R4 nonzero clears");

        // R6: mute path with nonzero data
        mute_done = 1'b1;
        mute_req  = 1'b1;
        for (int i = 0; i < ML; i++) frame(18'd7, 18'd7, "R6 mute hold");
        check_now(1'b1, "R6 after 9214 strobes");
        frame(18'h155, 18'h2aaa, "R6 data ignored while muted");

        // R8: release clears without a strobe
        mute_req = 1'b0;
        mrun = 0;
        @(negedge clk);
        check_now(1'b0, "R8 release");

        // R7: status low blocks mute path
        mute_done = 1'b0;
        mute_req  = 1'b1;
        for (int i = 0; i < 9300; i++) frame(18'd9, 18'd9, "R7 status low");
        mute_done = 1'b1;
        @(negedge clk);
        check_now(1'b1, "R7 status rises");

        // R8: restart needs another full hold
        mute_req = 1'b0;
        mrun = 0;
        @(negedge clk);
        check_now(1'b0, "R8 second release");
        mute_req = 1'b1;
        for (int i = 0; i < ML - 1; i++) frame(18'd4, 18'd4, "R8 rehold");
        check_now(1'b0, "R8 rehold at 9213");
        frame(18'd4, 18'd4, "R8 rehold at 9214");
        mute_req = 1'b0;
        mrun = 0;
        @(negedge clk);

        // R1: reset mid-run empties the zero counter
        for (int i = 0; i < 5000; i++) frame(18'd0, 18'd0, "R1 pre-reset run");
        rst_n = 1'b0;
        zrun = 0;
        @(negedge clk);
        check_now(1'b0, "R1 mid-run reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3200; i++) frame(18'd0, 18'd0, "R1 run restarted");
        check_now(1'b0, "R1 no carry-over");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule